// File: doc/BRIEF.md
# Flash Controller Protected Register File

This block is the register file of an embedded flash controller. A 32-bit single-port bus reaches the control word, three timing words, the target address and a status word. It passes the decoded command and timing fields straight to the operation sequencer that drives the flash array. A write-protect flag in the control word guards the control, timing and address registers. Software may change that flag only after writing a fixed series of three magic values into two unlock locations.

Writes that protection refuses leave the register untouched and raise a sticky error flag in the status word. Software clears the flag by writing a one to it. The status word also carries four live condition inputs from the flash macro. Reads are never gated. Read data appears on the cycle after the request.

Top module: `fctl_regfile`

## Requirements
- R1: After reset the control word reads 0x0000_0002 (protect flag at bit 1 set), the timing and address words read 0, and the error flag (status bit 1) is clear.
- R2: Byte offsets are control 0x00, timing0 0x04, timing1 0x08, timing2 0x0c, unlock-A 0x18, unlock-B 0x1c, address 0x20 and status 0x2c. A read returns data on `rdata_o` one clock after the request. Unused bits, the unlock locations and unmapped offsets read as zero.
- R3: While the protect flag is set, a write to timing0, timing1, timing2 or address leaves that register unchanged and sets the error flag.
- R4: While the protect flag is clear, writes to the timing and address words take effect. Timing0 keeps bits [5:0] and [31:16], timing1 keeps [23:0], and timing2 keeps [27:0].
- R5: Writing 0x7123 to unlock-A, then 0x812a to unlock-B, then 0xbee1 to unlock-A arms the next control write. That write may change any control bit, including the protect flag.
- R6: Arming lasts for exactly one control write. Writes to other registers neither use it up nor benefit from it, and a later control write needs a fresh sequence.
- R7: Any unlock-location write that does not match the next expected step returns the sequence to its start. This includes a write made while armed, which cancels the arming.
- R8: An unarmed control write while protection is off updates bits 0 and 3..8 and leaves the protect flag unchanged. If it tried to change the protect flag, it also sets the error flag. An unarmed control write while protection is on changes nothing and sets the error flag.
- R9: Writing status with bit 1 set clears the error flag. Writing status with bit 1 clear leaves the flag as it is. Status writes are never blocked.
- R10: Status bits 0, 2, 3 and 4 reflect `busy_i`, `redund_off_i`, `discharged_i` and `brownout_i`.
- R11: The decoded outputs equal the stored register fields: control bits 0 sleep, 1 protect, 3 mass erase, 4 page erase, 5 program, 6 reference erase, 7 trim recall, 8 auto-program; timing0 [5:0] wait states and [31:16] hold count; timing1 [23:0] erase count; timing2 [15:0] program count, [23:16] 100 ns count and [27:24] 10 ns count.
- R12: Reads return the current contents whether or not protection is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| busy_i | input | 1 | Operation in progress |
| redund_off_i | input | 1 | Redundancy disabled |
| discharged_i | input | 1 | Array discharged |
| brownout_i | input | 1 | Supply brown-out seen |
| sleep_o | output | 1 | Sleep request |
| wp_o | output | 1 | Protect flag |
| mass_erase_o | output | 1 | Mass erase command |
| page_erase_o | output | 1 | Page erase command |
| program_o | output | 1 | Program command |
| ref_erase_o | output | 1 | Reference cell erase command |
| trim_recall_o | output | 1 | Trim recall command |
| auto_prog_o | output | 1 | Auto-program command |
| rd_wait_o | output | 6 | Read wait states |
| hold_cyc_o | output | 16 | Hold time in cycles |
| erase_cyc_o | output | 24 | Erase time in cycles |
| prog_cyc_o | output | 16 | Program time in cycles |
| t100_cyc_o | output | 8 | Cycles per 100 ns |
| t10_cyc_o | output | 4 | Cycles per 10 ns |
| flash_addr_o | output | 32 | Operation address |

## Verification
The hardest state to reach is an armed sequence that is then disturbed before the control write arrives. A timing write may land while armed under protection, or an out-of-order unlock write may land after arming. The bench builds both cases from ports alone. It completes the three-step series and then inserts either a protected timing write or a stray unlock write. Only after that does it issue the control write. It checks by read-back that the timing word did not move, that the control write still succeeded or was refused, and that the error flag followed.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
  localparam logic [7:0] OFS_CTL  = 8'h00;
  localparam logic [7:0] OFS_TIM0 = 8'h04;
  localparam logic [7:0] OFS_TIM1 = 8'h08;
  localparam logic [7:0] OFS_TIM2 = 8'h0c;
  localparam logic [7:0] OFS_UNLA = 8'h18;
  localparam logic [7:0] OFS_UNLB = 8'h1c;
  localparam logic [7:0] OFS_ADDR = 8'h20;
  localparam logic [7:0] OFS_STAT = 8'h2c;

  localparam logic [31:0] KEY_FIRST  = 32'h0000_7123;
  localparam logic [31:0] KEY_SECOND = 32'h0000_812a;
  localparam logic [31:0] KEY_THIRD  = 32'h0000_bee1;

  localparam int WP_BIT = 1;
  localparam logic [31:0] CTL_ALL   = 32'h0000_01fb;
  localparam logic [31:0] CTL_NOWP  = 32'h0000_01f9;
  localparam logic [31:0] CTL_RESET = 32'h0000_0002;

  localparam int NUM_TIM = 3;

  function automatic logic [31:0] tim_mask(input int idx);
    case (idx)
      0:       return 32'hffff_003f;
      1:       return 32'h00ff_ffff;
      default: return 32'h0fff_ffff;
    endcase
  endfunction

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_STEP1 = 2'd1,
    UL_STEP2 = 2'd2,
    UL_ARMED = 2'd3
  } unlock_state_e;
endpackage

// File: rtl/fctl_unlock.sv
module fctl_unlock
  import fctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_a_i,
  input  logic        wr_b_i,
  input  logic        ctl_wr_i,
  input  logic [31:0] wdata_i,
  output logic        armed_o
);
  unlock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ctl_wr_i && state_q == UL_ARMED) begin
      state_d = UL_IDLE;
    end else if (wr_a_i) begin
      case (state_q)
        UL_STEP2: state_d = (wdata_i == KEY_THIRD) ? UL_ARMED : UL_IDLE;
        UL_STEP1: state_d = UL_IDLE;
        default:  state_d = (wdata_i == KEY_FIRST) ? UL_STEP1 : UL_IDLE;
      endcase
    end else if (wr_b_i) begin
      state_d = (state_q == UL_STEP1 && wdata_i == KEY_SECOND) ? UL_STEP2 : UL_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o = (state_q == UL_ARMED);

  AST_ARM_AFTER_STEP2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == UL_ARMED && $past(state_q) != UL_ARMED) |-> $past(state_q) == UL_STEP2); // R5
  AST_ARM_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && ctl_wr_i) |=> !armed_o); // R6
  AST_BAD_B_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b_i && state_q != UL_STEP1) |=> state_q == UL_IDLE); // R7
endmodule

// File: rtl/fctl_status.sv
module fctl_status (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_err_i,
  input  logic        clr_err_i,
  input  logic        busy_i,
  input  logic        redund_off_i,
  input  logic        discharged_i,
  input  logic        brownout_i,
  output logic        err_o,
  output logic [31:0] status_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (set_err_i) err_q <= 1'b1;
    else if (clr_err_i) err_q <= 1'b0;
  end

  assign err_o    = err_q;
  assign status_o = {27'd0, brownout_i, discharged_i, redund_off_i, err_q, busy_i};

  AST_ERR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !set_err_i) |=> !err_q); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_err_i) |=> err_q); // R9
endmodule

// File: rtl/fctl_regfile.sv
module fctl_regfile
  import fctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              busy_i,
  input  logic              redund_off_i,
  input  logic              discharged_i,
  input  logic              brownout_i,
  output logic              sleep_o,
  output logic              wp_o,
  output logic              mass_erase_o,
  output logic              page_erase_o,
  output logic              program_o,
  output logic              ref_erase_o,
  output logic              trim_recall_o,
  output logic              auto_prog_o,
  output logic [5:0]        rd_wait_o,
  output logic [15:0]       hold_cyc_o,
  output logic [23:0]       erase_cyc_o,
  output logic [15:0]       prog_cyc_o,
  output logic [7:0]        t100_cyc_o,
  output logic [3:0]        t10_cyc_o,
  output logic [31:0]       flash_addr_o
);
  logic wr, rd;
  logic sel_ctl, sel_a, sel_b, sel_addr, sel_stat;
  logic [NUM_TIM-1:0] sel_tim;
  logic [31:0] ctl_q, addr_q, rdata_q, status_w;
  logic [31:0] tim_q [NUM_TIM];
  logic wp, armed, err, ctl_wr;
  logic set_err, gated_hit, wp_change;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign sel_ctl  = (addr_i == ADDR_W'(OFS_CTL));
  assign sel_a    = (addr_i == ADDR_W'(OFS_UNLA));
  assign sel_b    = (addr_i == ADDR_W'(OFS_UNLB));
  assign sel_addr = (addr_i == ADDR_W'(OFS_ADDR));
  assign sel_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign sel_tim[0] = (addr_i == ADDR_W'(OFS_TIM0));
  assign sel_tim[1] = (addr_i == ADDR_W'(OFS_TIM1));
  assign sel_tim[2] = (addr_i == ADDR_W'(OFS_TIM2));

  assign wp     = ctl_q[WP_BIT];
  assign ctl_wr = wr & sel_ctl;

  fctl_unlock u_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_a_i   (wr & sel_a),
    .wr_b_i   (wr & sel_b),
    .ctl_wr_i (ctl_wr),
    .wdata_i  (wdata_i),
    .armed_o  (armed)
  );

  // error sources: protected data write, unarmed control write under protect,
  // unarmed attempt to flip the protect flag
  assign gated_hit = wr & (sel_addr | (|sel_tim));
  assign wp_change = wdata_i[WP_BIT] != wp;
  assign set_err   = (gated_hit & wp) | (ctl_wr & ~armed & (wp | wp_change));

  fctl_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_err_i    (set_err),
    .clr_err_i    (wr & sel_stat & wdata_i[1]),
    .busy_i       (busy_i),
    .redund_off_i (redund_off_i),
    .discharged_i (discharged_i),
    .brownout_i   (brownout_i),
    .err_o        (err),
    .status_o     (status_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_RESET;
    end else if (ctl_wr) begin
      if (armed)    ctl_q <= wdata_i & CTL_ALL;
      else if (!wp) ctl_q <= (wdata_i & CTL_NOWP) | (ctl_q & ~CTL_NOWP);
    end
  end

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     tim_q[g] <= '0;
      else if (wr && sel_tim[g] && !wp) tim_q[g] <= wdata_i & tim_mask(g);
    end

    AST_TIM_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr && sel_tim[g] && wp) |=> $stable(tim_q[g])); // R3
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   addr_q <= '0;
    else if (wr && sel_addr && !wp) addr_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (1'b1)
        sel_ctl:    rdata_q <= ctl_q;
        sel_tim[0]: rdata_q <= tim_q[0];
        sel_tim[1]: rdata_q <= tim_q[1];
        sel_tim[2]: rdata_q <= tim_q[2];
        sel_addr:   rdata_q <= addr_q;
        sel_stat:   rdata_q <= status_w;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o       = rdata_q;
  assign sleep_o       = ctl_q[0];
  assign wp_o          = wp;
  assign mass_erase_o  = ctl_q[3];
  assign page_erase_o  = ctl_q[4];
  assign program_o     = ctl_q[5];
  assign ref_erase_o   = ctl_q[6];
  assign trim_recall_o = ctl_q[7];
  assign auto_prog_o   = ctl_q[8];
  assign rd_wait_o     = tim_q[0][5:0];
  assign hold_cyc_o    = tim_q[0][31:16];
  assign erase_cyc_o   = tim_q[1][23:0];
  assign prog_cyc_o    = tim_q[2][15:0];
  assign t100_cyc_o    = tim_q[2][23:16];
  assign t10_cyc_o     = tim_q[2][27:24];
  assign flash_addr_o  = addr_q;

  AST_WP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp != $past(wp)) |-> $past(armed)); // R5
  AST_BLOCK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated_hit && wp) |=> err); // R3
  AST_ADDR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && sel_addr && wp) |=> $stable(addr_q)); // R3
  AST_CTL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !armed && wp) |=> $stable(ctl_q)); // R8
endmodule

// File: tb/fctl_regfile_test.sv
module fctl_regfile_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic busy = 0, rdo = 0, dis = 0, bo = 0;
  logic sleep, wp, me, pe, prg, re, tr, ap;
  logic [5:0] rw; logic [15:0] hc, pc; logic [23:0] ec;
  logic [7:0] t100; logic [3:0] t10; logic [31:0] fa;

  int n_cmp = 0, n_bad = 0;
  logic rd_q = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  fctl_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy), .redund_off_i(rdo),
    .discharged_i(dis), .brownout_i(bo), .sleep_o(sleep), .wp_o(wp),
    .mass_erase_o(me), .page_erase_o(pe), .program_o(prg), .ref_erase_o(re),
    .trim_recall_o(tr), .auto_prog_o(ap), .rd_wait_o(rw), .hold_cyc_o(hc),
    .erase_cyc_o(ec), .prog_cyc_o(pc), .t100_cyc_o(t100), .t10_cyc_o(t10),
    .flash_addr_o(fa)
  );

  always @(posedge clk) rd_q <= req & ~we;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); req = 0;
  endtask

  task automatic unlock();
    wr(8'h18, 32'h7123); wr(8'h1c, 32'h812a); wr(8'h18, 32'hbee1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, 32'h2, "R1 ctl");
    rd(8'h04, 32'h0, "R1 tim0");
    rd(8'h2c, 32'h0, "R1 status");
    chk("R1 wp_o", {31'd0, wp}, 32'd1);
    // R3 protected writes ignored, R12 reads still work
    wr(8'h04, 32'hffff_ffff);
    wr(8'h20, 32'h1234_5678);
    rd(8'h04, 32'h0, "R3 tim0 kept");
    rd(8'h20, 32'h0, "R3 addr kept");
    rd(8'h2c, 32'h2, "R3 err set");
    rd(8'h00, 32'h2, "R12 ctl read under protect");
    // R9 W1C
    wr(8'h2c, 32'h0);
    rd(8'h2c, 32'h2, "R9 write 0 keeps");
    wr(8'h2c, 32'h2);
    rd(8'h2c, 32'h0, "R9 write 1 clears");
    // R5 unlock and clear protect
    unlock();
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R5 ctl unprotected");
    rd(8'h2c, 32'h0, "R5 no err");
    // R4 R2 field masks
    wr(8'h04, 32'hffff_ffff);
    wr(8'h08, 32'hffff_ffff);
    wr(8'h0c, 32'hffff_ffff);
    wr(8'h20, 32'h1234_5678);
    rd(8'h04, 32'hffff_003f, "R4 tim0");
    rd(8'h08, 32'h00ff_ffff, "R4 tim1");
    rd(8'h0c, 32'h0fff_ffff, "R4 tim2");
    rd(8'h20, 32'h1234_5678, "R4 addr");
    // R11 decoded timing
    chk("R11 rd_wait", {26'd0, rw}, 32'h3f);
    chk("R11 hold", {16'd0, hc}, 32'hffff);
    chk("R11 erase", {8'd0, ec}, 32'hff_ffff);
    chk("R11 prog", {16'd0, pc}, 32'hffff);
    chk("R11 t100", {24'd0, t100}, 32'hff);
    chk("R11 t10", {28'd0, t10}, 32'hf);
    chk("R11 addr", fa, 32'h1234_5678);
    // R8 unarmed control write with protect off
    wr(8'h00, 32'hffff_ffff);
    rd(8'h00, 32'h1f9, "R8 ctl no wp");
    rd(8'h2c, 32'h2, "R8 wp change flagged");
    chk("R11 cmd bits", {24'd0, ap, tr, re, prg, pe, me, wp, sleep}, 32'hfd);
    wr(8'h2c, 32'h2);
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R8 ctl cleared");
    rd(8'h2c, 32'h0, "R8 no err w/o wp change");
    // R7 broken order
    wr(8'h18, 32'h7123); wr(8'h18, 32'h7123); wr(8'h1c, 32'h812a); wr(8'h18, 32'hbee1);
    wr(8'h00, 32'h2);
    rd(8'h00, 32'h0, "R7 broken seq not armed");
    rd(8'h2c, 32'h2, "R7 err");
    wr(8'h2c, 32'h2);
    // R6 single use
    unlock();
    wr(8'h00, 32'h2);
    rd(8'h00, 32'h2, "R6 armed write sets wp");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h2, "R6 second write blocked");
    rd(8'h2c, 32'h2, "R6 err");
    wr(8'h2c, 32'h2);
    // R6 timing write while armed is blocked but keeps arm
    unlock();
    wr(8'h08, 32'h5);
    rd(8'h08, 32'h00ff_ffff, "R6 tim1 blocked while armed");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R6 arm survives other write");
    rd(8'h2c, 32'h2, "R6 err from tim1");
    wr(8'h2c, 32'h2);
    // R7 stray unlock write cancels arming
    unlock();
    wr(8'h1c, 32'h0);
    wr(8'h00, 32'h2);
    rd(8'h00, 32'h0, "R7 arming cancelled");
    rd(8'h2c, 32'h2, "R7 err on cancelled");
    wr(8'h2c, 32'h2);
    // R10 live status
    busy = 1; rdo = 1; bo = 1;
    rd(8'h2c, 32'h15, "R10 status inputs");
    busy = 0; rdo = 0; dis = 1; bo = 0;
    rd(8'h2c, 32'h08, "R10 discharged");
    dis = 0;
    // R2 unused and unmapped
    rd(8'h18, 32'h0, "R2 unlock reads zero");
    rd(8'h10, 32'h0, "R2 unmapped zero");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    if (exp_q.size() != 0) chk("scoreboard-leftover", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule